// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block gives a five-stage in-order pipeline precise exceptions. It follows each instruction from fetch through decode and execute to the memory stage and carries a small record with it. The record holds a valid bit, the instruction address, a flag that marks a branch delay slot, and the exception state gathered so far. Exception requests enter as single-bit inputs, each tied to the instruction that sits in its stage in that cycle. These are an interrupt and a fetch address error at fetch, an illegal instruction at decode, and an arithmetic overflow at execute.

The unit does not carry a cause code to be decoded later. When a request is accepted, the detecting stage turns it into two write-enable bits, one for the cause register and one for the exception-PC register, plus the code value. The memory stage only tests these bits. In the cycle a marked instruction sits in memory, the unit does three things: it squashes that instruction and every younger one, it redirects fetch to the handler vector, and at the closing edge it writes the cause and exception-PC registers and enters kernel mode. A return-from-exception input sends fetch back to the saved address and drops to user mode.

The control is a two-state machine. ST_USER is normal execution. ST_KERNEL is the exception level, during which interrupts are masked. There are three transitions:
- T_TAKE goes from ST_USER to ST_KERNEL when an exception is committed.
- T_NEST stays in ST_KERNEL when an exception is committed in kernel mode.
- T_RETURN goes from ST_KERNEL to ST_USER when a return is accepted.

Top module: `pecu_commit_unit`

## Requirements
- R1: After reset the unit is in user mode (kernel_o=0). epc_o, cause_code_o and cause_bd_o are zero. redirect_o is 0 and flush_o is 0.
- R2: Let an instruction fetched in cycle n carry an exception. Then in cycle n+3, while it sits in memory, redirect_o=1, redirect_pc_o equals the VECTOR parameter (default 0x80000180) and flush_o=4'b1111. In flush_o, bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory.
- R3: At the edge that closes the commit cycle, cause_code_o takes the code of the exception. The codes are 0 for interrupt, 4 for fetch address error, 10 for illegal instruction and 12 for overflow.
- R4: On a commit from user mode, epc_o takes the instruction address, and cause_bd_o becomes 0. If the instruction was flagged as a delay slot, epc_o takes its address minus 4 and cause_bd_o becomes 1.
- R5: When several in-flight instructions carry exceptions, only the oldest commits. The younger ones, including an instruction fetched during the commit cycle, never cause a redirect.
- R6: Within one instruction, the request from the earliest stage decides the code, in the order fetch, decode, execute. At fetch, an interrupt beats an address error.
- R7: A commit enters kernel mode (kernel_o=1). While in kernel mode, interrupt requests are ignored.
- R8: An exception committed in kernel mode redirects to the vector and updates the cause. It leaves epc_o unchanged.
- R9: A return request in kernel mode raises redirect_o with redirect_pc_o=epc_o and flush_o=4'b0111, and the unit is in user mode from the next cycle. Exceptions of the squashed younger instructions never commit. A return request in user mode is ignored.
- R10: If an exception reaches memory in the same cycle as a return request, the exception is committed and the return is ignored.
- R11: A decode or execute request is ignored when that stage holds no valid instruction. A fetch request is ignored when fetch_valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | A new instruction enters fetch this cycle |
| fetch_pc_i | input | 32 | Address of the fetched instruction |
| fetch_bd_i | input | 1 | The fetched instruction is in a branch delay slot |
| int_req_i | input | 1 | Interrupt request, attached to the fetched instruction |
| fetch_adel_i | input | 1 | Fetch address error for the fetched instruction |
| dec_ri_i | input | 1 | Illegal instruction detected in decode |
| exe_ovf_i | input | 1 | Arithmetic overflow detected in execute |
| eret_i | input | 1 | Return-from-exception request from the memory stage |
| redirect_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | 32 | Restart address |
| flush_o | output | 4 | Squash mask, bit 0 fetch to bit 3 memory |
| epc_o | output | 32 | Saved restart address |
| cause_code_o | output | 5 | Exception code of the last commit |
| cause_bd_o | output | 1 | Last committed instruction was in a delay slot |
| kernel_o | output | 1 | Exception level / kernel mode |

## Verification
The assertions assume that a return request comes only from a valid instruction in the memory stage. They also assume that every request input belongs to the instruction in its own stage in that same cycle. The bench keeps to this by driving each request in the exact cycle its target instruction occupies the stage. It also drives returns only in cycles where the younger stages may legally be squashed. The properties further assume that the registers change only through a commit or a return. The stimulus therefore checks every redirect against a queued expectation and reads the registers a cycle later.

// File: rtl/pecu_pkg.sv
package pecu_pkg;
    parameter int unsigned PC_W = 32;
    typedef logic [PC_W-1:0] pc_t;

    // per-instruction record travelling down the pipe
    typedef struct packed {
        logic       valid;
        pc_t        pc;
        logic       in_slot;
        logic       cause_we;   // write enable for cause + status
        logic       epc_we;     // write enable for exception PC
        logic [4:0] code;
    } slot_t;

    typedef enum logic [0:0] {ST_USER, ST_KERNEL} mode_e;

    // detector order: fetch interrupt, fetch address, decode, execute
    localparam int unsigned N_SRC = 4;

    localparam logic [4:0] CODE_INT         = 5'd0;
    localparam logic [4:0] CODE_FETCH_ADDR  = 5'd4;
    localparam logic [4:0] CODE_ILLEGAL     = 5'd10;
    localparam logic [4:0] CODE_OVERFLOW    = 5'd12;

    function automatic logic [4:0] src_code(input int unsigned idx);
        case (idx)
            0:       return CODE_INT;
            1:       return CODE_FETCH_ADDR;
            2:       return CODE_ILLEGAL;
            default: return CODE_OVERFLOW;
        endcase
    endfunction
endpackage

// File: rtl/pecu_detect.sv
module pecu_detect
    import pecu_pkg::*;
#(
    parameter logic [4:0] CODE = 5'd0
) (
    input  slot_t slot_i,
    input  logic  req_i,
    input  logic  kernel_i,
    output slot_t slot_o
);
    // The first accepted request of an instruction wins (R6).
    // It is turned into write enables at once, so memory does no decode.
    always_comb begin
        slot_o = slot_i;
        if (slot_i.valid && req_i && !slot_i.cause_we) begin
            slot_o.cause_we = 1'b1;
            slot_o.epc_we   = !kernel_i;   // R8: epc kept in kernel mode
            slot_o.code     = CODE;
        end
    end
endmodule

// File: rtl/pecu_stage_regs.sv
module pecu_stage_regs
    import pecu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slot_t      de_d,
    input  slot_t      ex_d,
    input  slot_t      mem_d,
    input  logic [2:0] squash_i,   // bit0 fetch, bit1 decode, bit2 execute
    output slot_t      de_q,
    output slot_t      ex_q,
    output slot_t      mem_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q  <= '0;
            ex_q  <= '0;
            mem_q <= '0;
        end else begin
            de_q  <= squash_i[0] ? '0 : de_d;
            ex_q  <= squash_i[1] ? '0 : ex_d;
            mem_q <= squash_i[2] ? '0 : mem_d;
        end
    end
endmodule

// File: rtl/pecu_ctrl.sv
module pecu_ctrl
    import pecu_pkg::*;
#(
    parameter pc_t         VECTOR     = 32'h8000_0180,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  slot_t      mem_i,
    input  logic       eret_i,
    output logic       redirect_o,
    output pc_t        redirect_pc_o,
    output logic [3:0] flush_o,
    output pc_t        epc_o,
    output logic [4:0] cause_code_o,
    output logic       cause_bd_o,
    output logic       kernel_o
);
    localparam pc_t        STEP      = pc_t'(INSN_BYTES);
    localparam logic [3:0] SQ_ALL    = 4'b1111;
    localparam logic [3:0] SQ_YOUNG  = 4'b0111;

    mode_e state_q, state_d;
    logic  take, ret;
    pc_t   epc_q;
    logic [4:0] code_q;
    logic  bd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_USER;
        else        state_q <= state_d;
    end

    always_comb begin
        take          = mem_i.valid & mem_i.cause_we;
        ret           = 1'b0;
        state_d       = state_q;
        redirect_o    = 1'b0;
        redirect_pc_o = '0;
        flush_o       = '0;
        unique case (state_q)
            ST_USER: begin
                if (take) state_d = ST_KERNEL;           // T_TAKE
            end
            ST_KERNEL: begin
                if (take)        state_d = ST_KERNEL;    // T_NEST
                else if (eret_i) begin                   // T_RETURN
                    ret     = 1'b1;
                    state_d = ST_USER;
                end
            end
        endcase
        if (take) begin
            redirect_o    = 1'b1;
            redirect_pc_o = VECTOR;
            flush_o       = SQ_ALL;
        end else if (ret) begin
            redirect_o    = 1'b1;
            redirect_pc_o = epc_q;
            flush_o       = SQ_YOUNG;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q  <= '0;
            code_q <= '0;
            bd_q   <= 1'b0;
        end else if (take) begin
            code_q <= mem_i.code;
            bd_q   <= mem_i.in_slot;
            if (mem_i.epc_we)
                epc_q <= mem_i.in_slot ? mem_i.pc - STEP : mem_i.pc;
        end
    end

    assign epc_o        = epc_q;
    assign cause_code_o = code_q;
    assign cause_bd_o   = bd_q;
    assign kernel_o     = (state_q == ST_KERNEL);
endmodule

// File: rtl/pecu_commit_unit.sv
module pecu_commit_unit
    import pecu_pkg::*;
#(
    parameter pc_t         VECTOR     = 32'h8000_0180,
    parameter int unsigned INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid_i,
    input  logic [PC_W-1:0]  fetch_pc_i,
    input  logic             fetch_bd_i,
    input  logic             int_req_i,
    input  logic             fetch_adel_i,
    input  logic             dec_ri_i,
    input  logic             exe_ovf_i,
    input  logic             eret_i,
    output logic             redirect_o,
    output logic [PC_W-1:0]  redirect_pc_o,
    output logic [3:0]       flush_o,
    output logic [PC_W-1:0]  epc_o,
    output logic [4:0]       cause_code_o,
    output logic             cause_bd_o,
    output logic             kernel_o
);
    slot_t              fetch_slot;
    slot_t              de_q, ex_q, mem_q;
    slot_t              det_in  [N_SRC];
    slot_t              det_out [N_SRC];
    logic [N_SRC-1:0]   req;

    always_comb begin
        fetch_slot         = '0;
        fetch_slot.valid   = fetch_valid_i;
        fetch_slot.pc      = fetch_pc_i;
        fetch_slot.in_slot = fetch_bd_i;
    end

    // interrupts masked at exception level (R7)
    assign req = {exe_ovf_i, dec_ri_i, fetch_adel_i, int_req_i & ~kernel_o};

    assign det_in[0] = fetch_slot;
    assign det_in[1] = det_out[0];
    assign det_in[2] = de_q;
    assign det_in[3] = ex_q;

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_det
        pecu_detect #(.CODE(src_code(gi))) u_det (
            .slot_i   (det_in[gi]),
            .req_i    (req[gi]),
            .kernel_i (kernel_o),
            .slot_o   (det_out[gi])
        );
    end

    pecu_stage_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .de_d     (det_out[1]),
        .ex_d     (det_out[2]),
        .mem_d    (det_out[3]),
        .squash_i (flush_o[2:0]),
        .de_q     (de_q),
        .ex_q     (ex_q),
        .mem_q    (mem_q)
    );

    pecu_ctrl #(.VECTOR(VECTOR), .INSN_BYTES(INSN_BYTES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_i         (mem_q),
        .eret_i        (eret_i),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .flush_o       (flush_o),
        .epc_o         (epc_o),
        .cause_code_o  (cause_code_o),
        .cause_bd_o    (cause_bd_o),
        .kernel_o      (kernel_o)
    );
endmodule

// File: rtl/pecu_checker.sv
module pecu_checker #(
    parameter logic [31:0] VECTOR = 32'h8000_0180
) (
    input logic        clk,
    input logic        rst_n,
    input logic        redirect_o,
    input logic [31:0] redirect_pc_o,
    input logic [3:0]  flush_o,
    input logic [31:0] epc_o,
    input logic [4:0]  cause_code_o,
    input logic        cause_bd_o,
    input logic        kernel_o
);
    p_vector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && flush_o == 4'b1111) |-> redirect_pc_o == VECTOR);

    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (flush_o == 4'b1111 || flush_o == 4'b0111));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> flush_o == 4'b0000);

    p_enter_kernel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && flush_o == 4'b1111) |=> kernel_o);

    p_nested_epc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kernel_o && redirect_o && flush_o == 4'b1111) |=> $stable(epc_o));

    p_return_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && flush_o == 4'b0111) |-> (kernel_o && redirect_pc_o == epc_o));

    p_return_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && flush_o == 4'b0111) |=> !kernel_o);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |=> ($stable(epc_o) && $stable(cause_code_o)
                         && $stable(cause_bd_o) && $stable(kernel_o)));
endmodule

bind pecu_commit_unit pecu_checker #(.VECTOR(VECTOR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .flush_o       (flush_o),
    .epc_o         (epc_o),
    .cause_code_o  (cause_code_o),
    .cause_bd_o    (cause_bd_o),
    .kernel_o      (kernel_o)
);

// File: tb/pecu_commit_unit_tb.sv
`timescale 1ns/1ps
module pecu_commit_unit_tb;
    localparam logic [31:0] VEC = 32'h8000_0180;
    localparam logic [3:0]  ALL = 4'b1111;
    localparam logic [3:0]  YNG = 4'b0111;

    typedef struct {
        logic [31:0] tgt;
        logic [3:0]  fl;
        logic [31:0] epc;
        logic [4:0]  code;
        logic        bd;
        logic        kern;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_valid_i = 0, fetch_bd_i = 0, int_req_i = 0, fetch_adel_i = 0;
    logic dec_ri_i = 0, exe_ovf_i = 0, eret_i = 0;
    logic [31:0] fetch_pc_i = '0;
    logic        redirect_o, cause_bd_o, kernel_o;
    logic [31:0] redirect_pc_o, epc_o;
    logic [3:0]  flush_o;
    logic [4:0]  cause_code_o;

    int n_chk = 0;
    int n_fail = 0;
    exp_t exp_q[$];
    exp_t pend;
    bit   pend_v = 0;

    always #2.5 clk = ~clk;

    pecu_commit_unit u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] tgt, input logic [3:0] fl, input logic [31:0] epc,
                        input logic [4:0] code, input logic bd, input logic kern, input string req);
        exp_t e;
        e.tgt = tgt; e.fl = fl; e.epc = epc; e.code = code; e.bd = bd; e.kern = kern; e.req = req;
        exp_q.push_back(e);
    endtask

    // drive one cycle of inputs at a falling edge
    task automatic step(input logic v, input logic [31:0] pc, input logic bd, input logic adel,
                        input logic ri, input logic ovf, input logic intr, input logic eret);
        fetch_valid_i = v; fetch_pc_i = pc; fetch_bd_i = bd; fetch_adel_i = adel;
        dec_ri_i = ri; exe_ovf_i = ovf; int_req_i = intr; eret_i = eret;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 32'h0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic none_left(input string req);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // monitor: samples 1 ns before each rising edge
    always begin
        @(negedge clk);
        #1.5;
        if (rst_n) begin
            if (pend_v) begin
                chk(epc_o == pend.epc, {pend.req, " epc"}, epc_o, pend.epc);
                chk(cause_code_o == pend.code, {pend.req, " code"}, 32'(cause_code_o), 32'(pend.code));
                chk(cause_bd_o == pend.bd, {pend.req, " bd"}, 32'(cause_bd_o), 32'(pend.bd));
                chk(kernel_o == pend.kern, {pend.req, " mode"}, 32'(kernel_o), 32'(pend.kern));
                pend_v = 0;
            end
            if (redirect_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected redirect", redirect_pc_o, 32'h0);
                end else begin
                    pend = exp_q.pop_front();
                    chk(redirect_pc_o == pend.tgt, {pend.req, " target"}, redirect_pc_o, pend.tgt);
                    chk(flush_o == pend.fl, {pend.req, " flush"}, 32'(flush_o), 32'(pend.fl));
                    pend_v = 1;
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        chk(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1.5;
        // R1 reset state
        chk(kernel_o == 0, "R1 mode", 32'(kernel_o), 0);
        chk(epc_o == 0, "R1 epc", epc_o, 0);
        chk(cause_code_o == 0 && cause_bd_o == 0, "R1 cause", 32'(cause_code_o), 0);
        chk(redirect_o == 0 && flush_o == 0, "R1 redirect", 32'(flush_o), 0);
        @(negedge clk);

        // R2 R3 R4: overflow, squash of fetch during commit (R5)
        push(VEC, ALL, 32'h100, 5'd12, 0, 1, "R2 R3 R4 ovf");
        step(1, 32'h100, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        step(1, 32'h104, 0, 1, 0, 0, 0, 0);
        idle(3);
        push(32'h100, YNG, 32'h100, 5'd12, 0, 0, "R9 return");
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(2);
        none_left("R5 after ovf");

        // R4 delay slot, illegal instruction
        push(VEC, ALL, 32'h200, 5'd10, 1, 1, "R4 R3 delay slot");
        step(1, 32'h200, 0, 0, 0, 0, 0, 0);
        step(1, 32'h204, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        idle(4);
        // R9 return squashes younger ones carrying an overflow
        push(32'h200, YNG, 32'h200, 5'd10, 1, 0, "R9 return squash");
        step(1, 32'h900, 0, 0, 0, 0, 0, 0);
        step(1, 32'h904, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 1);
        idle(5);
        none_left("R9 squashed younger");

        // R5 simultaneous exceptions: oldest wins
        push(VEC, ALL, 32'h300, 5'd12, 0, 1, "R5 oldest");
        step(1, 32'h300, 0, 0, 0, 0, 0, 0);
        step(1, 32'h304, 0, 0, 0, 0, 0, 0);
        step(1, 32'h308, 0, 1, 1, 1, 0, 0);
        step(1, 32'h30c, 0, 1, 0, 0, 0, 0);
        idle(5);
        none_left("R5 younger dropped");
        push(32'h300, YNG, 32'h300, 5'd12, 0, 0, "R9 return");
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(2);

        // R6 earliest stage within one instruction
        push(VEC, ALL, 32'h400, 5'd4, 0, 1, "R6 fetch first");
        step(1, 32'h400, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        idle(4);
        push(32'h400, YNG, 32'h400, 5'd4, 0, 0, "R9 return");
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(2);

        // R6 R7 interrupt beats address error, enters kernel
        push(VEC, ALL, 32'h500, 5'd0, 0, 1, "R6 R7 interrupt");
        step(1, 32'h500, 0, 1, 0, 0, 1, 0);
        idle(5);
        // R7 interrupt masked in kernel
        step(1, 32'h600, 0, 0, 0, 0, 1, 0);
        idle(5);
        none_left("R7 masked");
        chk(kernel_o == 1, "R7 still kernel", 32'(kernel_o), 1);

        // R8 nested exception keeps epc
        push(VEC, ALL, 32'h500, 5'd12, 0, 1, "R8 nested");
        step(1, 32'h700, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        idle(4);

        // R10 exception and return in the same cycle
        push(VEC, ALL, 32'h500, 5'd10, 0, 1, "R10 exception wins");
        step(1, 32'h800, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(3);
        push(32'h500, YNG, 32'h500, 5'd10, 0, 0, "R9 return");
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(2);

        // R9 return in user mode ignored
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(3);
        none_left("R9 user return");
        chk(kernel_o == 0, "R9 stays user", 32'(kernel_o), 0);

        // R11 requests on empty stages ignored
        step(0, 32'h0, 0, 1, 1, 1, 0, 0);
        idle(5);
        none_left("R11 empty stages");
        chk(cause_code_o == 5'd10 && kernel_o == 0, "R11 state kept", 32'(cause_code_o), 10);

        chk(pend_v == 0, "final pending", 32'(pend_v), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule